// File: doc/BRIEF.md
# Two-Generator Sensing Matrix Column Source

This block supplies, for every incoming sample of a compressed-sensing encoder, one column of a pseudo-random binary sensing matrix. Each bit of that column says whether the matching row accumulator should add the sample. The rows come from only two linear feedback shift registers rather than one per row. Row bit i is the XOR of bit i of the wide generator's state with the newest bit of the second, independent generator. This keeps the rows decorrelated at a small fraction of the register cost.

Both generators advance once for each accepted sample. At every frame boundary they return to their programmed seeds, so every frame is encoded with the same matrix and a receiver can rebuild it. Software-side configuration (two seeds and two feedback tap masks) is captured into pending registers and applied only at a frame boundary. The tap masks select both the polynomial and the effective length of each generator.

Top module: `rand_matrix_gen`

## Requirements
- R1: While reset is held, and after it until the first load or step, generator A holds DEF_SEED_A and generator B holds DEF_SEED_B, so `row_en` equals DEF_SEED_A[ROWS-1:0] XOR (ROWS copies of DEF_SEED_B[0]). Both default seeds are non-zero. Both tap masks hold their defaults, and so do the pending seeds and masks.
- R2: `row_en[i]` always equals bit i of generator A XOR bit 0 of generator B. It is therefore valid in the same cycle as the `smp_stb` of the sample it belongs to.
- R3: On a clock edge with `smp_stb` high and `frame_end` low, each generator shifts left by one bit. Bit 0 receives the XOR-reduction of (state AND active tap mask).
- R4: On an edge with neither `smp_stb` nor `frame_end` high, both generators keep their state, whatever `cfg_wr` does.
- R5: On an edge with `frame_end` high, both generators load the pending seeds, whether `smp_stb` is high or not. With unchanged configuration, every frame therefore sees the same sequence of `row_en` columns.
- R6: `cfg_wr` stores `cfg_seed_a`, `cfg_taps_a`, `cfg_seed_b` and `cfg_taps_b` into pending registers. They change neither the running sequence nor the active taps until the next `frame_end`. A write in the same cycle as `frame_end` waits for the following boundary.
- R7: A pending seed of all zeros is loaded as the value 1 (only bit 0 set). A zero seed on both generators thus yields `row_en` with bit 0 clear and all other bits set.
- R8: The tap mask sets the polynomial and the length. With taps at bits 6 and 5 only (x^7+x^6+1), bits 6..0 of generator A repeat every 127 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | A sample is accepted this cycle |
| frame_end | input | 1 | Frame boundary: reload seeds, apply pending taps |
| cfg_wr | input | 1 | Capture the four configuration words into pending registers |
| cfg_seed_a | input | LEN_A | Seed for generator A |
| cfg_taps_a | input | LEN_A | Feedback tap mask for generator A |
| cfg_seed_b | input | LEN_B | Seed for generator B |
| cfg_taps_b | input | LEN_B | Feedback tap mask for generator B |
| row_en | output | ROWS | Row enables for the current sample |

## Verification
Several properties are checked on every cycle from the ports alone. The column holds still on idle cycles even when configuration is written. After a step, row bits move up by one once the shared B bit is cancelled out. The column right after a boundary repeats the previous frame's first column while no configuration was written. The reset value also appears on the output. The exact feedback bit is not checked cycle by cycle. The bench shows that part against an independent model, together with deferred configuration, the zero-seed substitution, the priority of a boundary over a sample, and the 127-step period of a short programmed polynomial.

// File: rtl/rand_matrix_gen.sv
module rand_matrix_gen #(
  parameter int ROWS  = 50,
  parameter int LEN_A = 64,
  parameter int LEN_B = 32,
  parameter logic [LEN_A-1:0] DEF_SEED_A = 64'hACE1_2468_9BDF_1357,
  parameter logic [LEN_A-1:0] DEF_TAPS_A = 64'hD800_0000_0000_0000,
  parameter logic [LEN_B-1:0] DEF_SEED_B = 32'h1234_5679,
  parameter logic [LEN_B-1:0] DEF_TAPS_B = 32'h8020_0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic             frame_end,
  input  logic             cfg_wr,
  input  logic [LEN_A-1:0] cfg_seed_a,
  input  logic [LEN_A-1:0] cfg_taps_a,
  input  logic [LEN_B-1:0] cfg_seed_b,
  input  logic [LEN_B-1:0] cfg_taps_b,
  output logic [ROWS-1:0]  row_en
);

  localparam logic [LEN_A-1:0] ONE_A = {{(LEN_A-1){1'b0}}, 1'b1};
  localparam logic [LEN_B-1:0] ONE_B = {{(LEN_B-1){1'b0}}, 1'b1};

  logic [LEN_A-1:0] st_a, taps_a, pend_seed_a, pend_taps_a;
  logic [LEN_B-1:0] st_b, taps_b, pend_seed_b, pend_taps_b;

  wire fb_a = ^(st_a & taps_a);
  wire fb_b = ^(st_b & taps_b);

  wire [LEN_A-1:0] load_a = (pend_seed_a == '0) ? ONE_A : pend_seed_a;
  wire [LEN_B-1:0] load_b = (pend_seed_b == '0) ? ONE_B : pend_seed_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_seed_a <= DEF_SEED_A;
      pend_taps_a <= DEF_TAPS_A;
      pend_seed_b <= DEF_SEED_B;
      pend_taps_b <= DEF_TAPS_B;
    end else if (cfg_wr) begin
      pend_seed_a <= cfg_seed_a;
      pend_taps_a <= cfg_taps_a;
      pend_seed_b <= cfg_seed_b;
      pend_taps_b <= cfg_taps_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_a   <= (DEF_SEED_A == '0) ? ONE_A : DEF_SEED_A;
      st_b   <= (DEF_SEED_B == '0) ? ONE_B : DEF_SEED_B;
      taps_a <= DEF_TAPS_A;
      taps_b <= DEF_TAPS_B;
    end else if (frame_end) begin
      st_a   <= load_a;
      st_b   <= load_b;
      taps_a <= pend_taps_a;
      taps_b <= pend_taps_b;
    end else if (smp_stb) begin
      st_a <= {st_a[LEN_A-2:0], fb_a};
      st_b <= {st_b[LEN_B-2:0], fb_b};
    end
  end

  assign row_en = st_a[ROWS-1:0] ^ {ROWS{st_b[0]}};

endmodule

module rand_matrix_gen_chk #(
  parameter int ROWS = 50,
  parameter logic [ROWS-1:0] RST_VEC = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_stb,
  input logic            frame_end,
  input logic            cfg_wr,
  input logic [ROWS-1:0] row_en
);

  logic            fe_d, dirty, chk_ok, have_ref;
  logic [ROWS-1:0] ref_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_d     <= 1'b0;
      dirty    <= 1'b0;
      chk_ok   <= 1'b0;
      have_ref <= 1'b0;
      ref_vec  <= '0;
    end else begin
      fe_d <= frame_end;
      if (frame_end) begin
        chk_ok <= have_ref && !dirty;
        dirty  <= cfg_wr;
      end else if (cfg_wr) begin
        dirty <= 1'b1;
      end
      if (fe_d) begin
        ref_vec  <= row_en;
        have_ref <= 1'b1;
      end
    end
  end

  assert_reset_value_R1: assert property (@(posedge clk)
    !rst_n |=> row_en == RST_VEC);

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && !frame_end |=>
      (row_en[ROWS-1:2] ^ {(ROWS-2){row_en[1]}}) ==
      $past(row_en[ROWS-2:1] ^ {(ROWS-2){row_en[0]}}));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb && !frame_end |=> $stable(row_en));

  assert_frame_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fe_d && chk_ok |-> row_en == ref_vec);

endmodule

bind rand_matrix_gen rand_matrix_gen_chk #(
  .ROWS(ROWS),
  .RST_VEC(DEF_SEED_A[ROWS-1:0] ^ {ROWS{DEF_SEED_B[0]}})
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .frame_end(frame_end),
  .cfg_wr(cfg_wr), .row_en(row_en)
);

// File: tb/test_rand_matrix_gen.sv
module test_rand_matrix_gen;
  localparam int ROWS = 50;
  localparam int LA = 64;
  localparam int LB = 32;
  localparam logic [LA-1:0] DSA = 64'hACE1_2468_9BDF_1357;
  localparam logic [LA-1:0] DTA = 64'hD800_0000_0000_0000;
  localparam logic [LB-1:0] DSB = 32'h1234_5679;
  localparam logic [LB-1:0] DTB = 32'h8020_0003;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0, frame_end = 1'b0, cfg_wr = 1'b0;
  logic [LA-1:0] cfg_seed_a = '0, cfg_taps_a = '0;
  logic [LB-1:0] cfg_seed_b = '0, cfg_taps_b = '0;
  logic [ROWS-1:0] row_en;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [LA-1:0] ma, ta, psa, pta;
  logic [LB-1:0] mb, tb, psb, ptb;

  always #4 clk = ~clk;

  rand_matrix_gen i_rand_matrix_gen (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .frame_end(frame_end),
    .cfg_wr(cfg_wr), .cfg_seed_a(cfg_seed_a), .cfg_taps_a(cfg_taps_a),
    .cfg_seed_b(cfg_seed_b), .cfg_taps_b(cfg_taps_b), .row_en(row_en)
  );

  function automatic logic [ROWS-1:0] exp_vec();
    return ma[ROWS-1:0] ^ {ROWS{mb[0]}};
  endfunction

  function automatic logic [LA-1:0] fix_a(input logic [LA-1:0] s);
    return (s == '0) ? LA'(1) : s;
  endfunction

  function automatic logic [LB-1:0] fix_b(input logic [LB-1:0] s);
    return (s == '0) ? LB'(1) : s;
  endfunction

  task automatic check_vec(input logic [ROWS-1:0] exp, input string tag);
    checks++;
    if (row_en !== exp) begin
      failures++;
      $display("FAIL %s row_en actual=%h expected=%h", tag, row_en, exp);
    end
  endtask

  task automatic step(input logic stb, input logic fe, input logic wr,
                      input logic [LA-1:0] sa, input logic [LA-1:0] tpa,
                      input logic [LB-1:0] sb, input logic [LB-1:0] tpb,
                      input string tag);
    smp_stb = stb; frame_end = fe; cfg_wr = wr;
    cfg_seed_a = sa; cfg_taps_a = tpa; cfg_seed_b = sb; cfg_taps_b = tpb;
    #1;
    check_vec(exp_vec(), tag);
    @(posedge clk);
    if (fe) begin
      ma = fix_a(psa); mb = fix_b(psb); ta = pta; tb = ptb;
    end else if (stb) begin
      ma = {ma[LA-2:0], ^(ma & ta)};
      mb = {mb[LB-2:0], ^(mb & tb)};
    end
    if (wr) begin
      psa = sa; pta = tpa; psb = sb; ptb = tpb;
    end
    @(negedge clk);
    smp_stb = 0; frame_end = 0; cfg_wr = 0;
  endtask

  task automatic run(input logic stb, input logic fe, input string tag);
    step(stb, fe, 1'b0, '0, '0, '0, '0, tag);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [ROWS-1:0] frame_rec [20];
    logic [5:0] ref7;
    void'($urandom(32'd2718));
    ma = DSA; mb = DSB; ta = DTA; tb = DTB;
    psa = DSA; pta = DTA; psb = DSB; ptb = DTB;
    repeat (3) @(negedge clk);
    #1;
    check_vec(DSA[ROWS-1:0] ^ {ROWS{DSB[0]}}, "R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check_vec(DSA[ROWS-1:0] ^ {ROWS{DSB[0]}}, "R1 value after release");

    for (int k = 0; k < 100; k++) run(1'b1, 1'b0, "R2 R3 consecutive steps");
    for (int k = 0; k < 8; k++) run(1'b0, 1'b0, "R4 idle hold");
    for (int k = 0; k < 100; k++) run(1'($urandom % 2), 1'b0, "R3 sparse strobes");

    run(1'b1, 1'b1, "R5 boundary with sample");
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 20; k++) begin
        #1;
        if (f == 0) frame_rec[k] = row_en;
        else check_vec(frame_rec[k], "R5 frame repeats");
        run(1'b1, k == 19, "R5 frame sequence");
      end
    end
    run(1'b0, 1'b1, "R5 boundary without sample");
    check_vec(frame_rec[0], "R5 reload without sample");

    for (int k = 0; k < 5; k++) run(1'b1, 1'b0, "R6 before write");
    step(1'b0, 1'b0, 1'b1, 64'h0F0F_1234_5678_9ABC, DTA, 32'h0BAD_F00D, DTB,
         "R6 write cycle");
    for (int k = 0; k < 10; k++) run(1'b1, 1'b0, "R6 write deferred");
    run(1'b1, 1'b1, "R6 boundary applies write");
    check_vec(exp_vec(), "R6 new seed in use");

    step(1'b0, 1'b0, 1'b1, '0, DTA, '0, DTB, "R7 zero seed write");
    run(1'b0, 1'b1, "R7 boundary");
    check_vec({{(ROWS-1){1'b1}}, 1'b0}, "R7 zero seed substituted");
    for (int k = 0; k < 10; k++) run(1'b1, 1'b0, "R7 runs from one");

    step(1'b0, 1'b0, 1'b1, 64'h5B, 64'h60, DSB, DTB, "R8 short taps write");
    run(1'b0, 1'b1, "R8 boundary");
    #1;
    ref7 = row_en[6:1] ^ {6{row_en[0]}};
    for (int k = 0; k < 127; k++) run(1'b1, 1'b0, "R8 short polynomial");
    #1;
    checks++;
    if ((row_en[6:1] ^ {6{row_en[0]}}) !== ref7) begin
      failures++;
      $display("FAIL R8 period actual=%h expected=%h",
               row_en[6:1] ^ {6{row_en[0]}}, ref7);
    end

    for (int k = 0; k < 3000; k++) begin
      logic wr;
      logic [LA-1:0] sa;
      logic [LB-1:0] sb;
      wr = ($urandom % 50) == 0;
      sa = (($urandom % 8) == 0) ? '0 : r64();
      sb = (($urandom % 8) == 0) ? '0 : $urandom;
      step(1'($urandom % 2), ($urandom % 40) == 0, wr, sa, r64() | 64'h8000_0000_0000_0000,
           sb, $urandom | 32'h8000_0000, "R2 R3 R5 R6 random mix");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule